// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Capture

This block gives software control of a set of general-purpose pins, grouped into banks of 32 pins each. There are at most three banks. A pin is an input or an output, set by its direction bit. Output levels are held in a latch. Software changes that latch only by writing ones to a set word or to a clear word, so no read-modify-write is needed. Every pin input goes through a two-flop synchronizer. Rising and falling transitions of the synchronized value can each be enabled per pin to capture into a sticky status word. Software clears a status bit by writing a one to it.

Registers are word addressed. Each register type owns one word per bank, and the words for bank n sit at the type's base plus 4*n. The bases are: level 0x00, direction 0x0C, set 0x18, clear 0x24, rising enable 0x30, falling enable 0x3C, status 0x48 and interrupt mask 0x9C. A single interrupt line is the OR, over all banks, of status bits ANDed with their mask bits. If the pin count is not a multiple of 32, the last bank is partial.

Top module: `egpio_ctrl`

## Requirements
- R1: A word at type base + 4*n addresses bank n. A read of any other offset returns zero, including a misaligned one or one beyond the implemented banks, and a write to it changes no register.
- R2: After reset, the following are all zero: direction, output latch, rising and falling enables, status and mask. pin_oe_o, pin_o and irq_o are low.
- R3: Writing the set word (0x18) makes the latch bit high wherever the written bit is 1. Bits written as 0 leave the latch as it was.
- R4: Writing the clear word (0x24) makes the latch bit low wherever the written bit is 1. Bits written as 0 leave the latch as it was.
- R5: A direction bit of 1 raises pin_oe_o for that pin, and pin_o carries its latch bit. A direction bit of 0 lowers pin_oe_o.
- R6: A level read returns the latch bit for output pins. For input pins it returns pin_i after a two-flop synchronizer: a change made just after a clock edge is visible after the second following edge and not after the first.
- R7: A status bit sets when its synchronized input rises with the rising enable set, or falls with the falling enable set. It sets on the third clock edge after the pin change. With both enables set, either direction is captured. With neither set, nothing is captured.
- R8: Status bits stay set until software writes 1 to them. Bits written 0 are unchanged. Writing all ones clears the bank.
- R9: When a new edge and a clearing write hit the same status bit on the same edge, the bit ends up set.
- R10: irq_o is high exactly when some status bit and its mask bit are both 1. A status bit whose mask bit is 0 does not raise irq_o.
- R11: Bits of the last bank above its implemented pin count read as zero, and writes to them have no effect.
- R12: The set and clear words read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte address of the register word |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid in the cycle of a read request |
| pin_i | input | NUM_PINS | Pad input levels |
| pin_o | output | NUM_PINS | Output latch |
| pin_oe_o | output | NUM_PINS | Output enable (direction) |
| irq_o | output | 1 | Combined masked edge interrupt |

## Verification
The bench goes after the cycle in which a clearing write and a freshly detected edge land on the same status bit. A design where the clear wins would lose that edge and read back zero. It times level reads one edge after a pin change and again two edges after, so a design with one synchronizer flop too few or too many shows the wrong value in one of those reads. It also writes all ones into the partial last bank and into a misaligned offset. A design that does not trim its width, or that decodes loosely, then reads back stray bits or corrupts a neighbouring bank. A design that lets unmasked status through would show irq_o high while its mask is still zero.

// File: rtl/egpio_pkg.sv
package egpio_pkg;
  typedef enum logic [3:0] {
    K_LVL  = 4'd0,
    K_DIR  = 4'd1,
    K_SET  = 4'd2,
    K_CLR  = 4'd3,
    K_RISE = 4'd4,
    K_FALL = 4'd5,
    K_STAT = 4'd6,
    K_MASK = 4'd7,
    K_NONE = 4'd8
  } reg_kind_e;

  localparam int unsigned TYPE_STRIDE = 12;    // three bank words per type
  localparam logic [7:0]  MASK_BASE   = 8'h9C;

  typedef struct packed {
    reg_kind_e  kind;
    logic [1:0] bank;
  } reg_sel_t;

  function automatic reg_sel_t decode_addr(input logic [7:0] a);
    reg_sel_t s;
    s.kind = K_NONE;
    s.bank = 2'd0;
    if (a[1:0] == 2'b00) begin
      for (int k = 0; k < 7; k++) begin
        if (a >= 8'(TYPE_STRIDE * k) && a < 8'(TYPE_STRIDE * k + TYPE_STRIDE)) begin
          s.kind = reg_kind_e'(4'(k));
          s.bank = 2'((a - 8'(TYPE_STRIDE * k)) >> 2);
        end
      end
      if (a >= MASK_BASE && a < MASK_BASE + 8'(TYPE_STRIDE)) begin
        s.kind = K_MASK;
        s.bank = 2'((a - MASK_BASE) >> 2);
      end
    end
    return s;
  endfunction
endpackage

// File: rtl/egpio_edge_det.sv
module egpio_edge_det #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] rose_o,
  output logic [W-1:0] fell_o
);
  logic [W-1:0] s1_q, s2_q, prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q   <= '0;
      s2_q   <= '0;
      prev_q <= '0;
    end else begin
      s1_q   <= pin_i;
      s2_q   <= s1_q;
      prev_q <= s2_q;
    end
  end

  assign lvl_o  = s2_q;
  assign rose_o = s2_q & ~prev_q;
  assign fell_o = ~s2_q & prev_q;
endmodule

// File: rtl/egpio_bank.sv
module egpio_bank
  import egpio_pkg::*;
#(
  parameter int P = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [7:0]   wr_i,      // one-hot by reg_kind_e
  input  logic [31:0]  wdata_i,
  input  logic [P-1:0] pin_i,
  output logic [P-1:0] pin_o,
  output logic [P-1:0] oe_o,
  output logic [31:0]  lvl_o,
  output logic [31:0]  dir_o,
  output logic [31:0]  rise_o,
  output logic [31:0]  fall_o,
  output logic [31:0]  stat_o,
  output logic [31:0]  mask_o,
  output logic         irq_o
);
  logic [P-1:0] w;
  logic [P-1:0] dir_q, out_q, rise_q, fall_q, stat_q, mask_q;
  logic [P-1:0] sync_lvl, rose, fell, edge_hit, stat_clr;

  assign w = wdata_i[P-1:0];

  egpio_edge_det #(.W(P)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (pin_i),
    .lvl_o  (sync_lvl),
    .rose_o (rose),
    .fell_o (fell)
  );

  assign edge_hit = (rise_q & rose) | (fall_q & fell);
  assign stat_clr = wr_i[K_STAT] ? w : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q  <= '0;
      out_q  <= '0;
      rise_q <= '0;
      fall_q <= '0;
      stat_q <= '0;
      mask_q <= '0;
    end else begin
      if (wr_i[K_DIR])  dir_q  <= w;
      if (wr_i[K_RISE]) rise_q <= w;
      if (wr_i[K_FALL]) fall_q <= w;
      if (wr_i[K_MASK]) mask_q <= w;
      if (wr_i[K_SET])      out_q <= out_q | w;
      else if (wr_i[K_CLR]) out_q <= out_q & ~w;
      // a fresh edge overrides a same-cycle clear
      stat_q <= (stat_q & ~stat_clr) | edge_hit;
    end
  end

  assign pin_o  = out_q;
  assign oe_o   = dir_q;
  assign lvl_o  = 32'((dir_q & out_q) | (~dir_q & sync_lvl));
  assign dir_o  = 32'(dir_q);
  assign rise_o = 32'(rise_q);
  assign fall_o = 32'(fall_q);
  assign stat_o = 32'(stat_q);
  assign mask_o = 32'(mask_q);
  assign irq_o  = |(stat_q & mask_q);

  a_r7_set_needs_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((stat_q & ~$past(stat_q) & ~$past(edge_hit)) == '0));

  a_r8_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(stat_q) & ~stat_q & ~$past(stat_clr)) == '0));

  a_r9_edge_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((~stat_q & $past(edge_hit)) == '0));

  a_r3_set_latch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i[K_SET] |=> ((out_q & $past(w)) == $past(w)));

  a_r4_clr_latch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i[K_CLR] |=> ((out_q & $past(w)) == '0));
endmodule

// File: rtl/egpio_ctrl.sv
module egpio_ctrl
  import egpio_pkg::*;
#(
  parameter int NUM_PINS = 84,
  parameter int ADDR_W   = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [31:0]         wdata_i,
  output logic [31:0]         rdata_o,
  input  logic [NUM_PINS-1:0] pin_i,
  output logic [NUM_PINS-1:0] pin_o,
  output logic [NUM_PINS-1:0] pin_oe_o,
  output logic                irq_o
);
  localparam int NUM_BANKS = (NUM_PINS + 31) / 32;
  localparam int LAST_PINS = NUM_PINS - 32 * (NUM_BANKS - 1);

  reg_sel_t sel;
  logic     hit, wr_hit, rd_hit;

  assign sel    = decode_addr(8'(addr_i));
  assign hit    = (sel.kind != K_NONE) && (int'(sel.bank) < NUM_BANKS)
                  && (addr_i >> 8) == '0;
  assign wr_hit = req_i && we_i && hit;
  assign rd_hit = req_i && !we_i && hit;

  logic [31:0] lvl_w  [NUM_BANKS];
  logic [31:0] dir_w  [NUM_BANKS];
  logic [31:0] rise_w [NUM_BANKS];
  logic [31:0] fall_w [NUM_BANKS];
  logic [31:0] stat_w [NUM_BANKS];
  logic [31:0] mask_w [NUM_BANKS];
  logic [NUM_BANKS-1:0] irq_w;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam int BP = (b == NUM_BANKS - 1) ? LAST_PINS : 32;
    logic [7:0] wr_b;
    assign wr_b = (wr_hit && sel.bank == 2'(b)) ? (8'd1 << sel.kind) : 8'd0;

    egpio_bank #(.P(BP)) u_bank (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_i    (wr_b),
      .wdata_i (wdata_i),
      .pin_i   (pin_i[b*32 +: BP]),
      .pin_o   (pin_o[b*32 +: BP]),
      .oe_o    (pin_oe_o[b*32 +: BP]),
      .lvl_o   (lvl_w[b]),
      .dir_o   (dir_w[b]),
      .rise_o  (rise_w[b]),
      .fall_o  (fall_w[b]),
      .stat_o  (stat_w[b]),
      .mask_o  (mask_w[b]),
      .irq_o   (irq_w[b])
    );
  end

  always_comb begin
    rdata_o = '0;
    if (rd_hit) begin
      case (sel.kind)
        K_LVL:   rdata_o = lvl_w[sel.bank];
        K_DIR:   rdata_o = dir_w[sel.bank];
        K_RISE:  rdata_o = rise_w[sel.bank];
        K_FALL:  rdata_o = fall_w[sel.bank];
        K_STAT:  rdata_o = stat_w[sel.bank];
        K_MASK:  rdata_o = mask_w[sel.bank];
        default: rdata_o = '0;  // set/clear are write-only
      endcase
    end
  end

  assign irq_o = |irq_w;

  a_r2_irq_quiet_reset: assert property (@(posedge clk_i)
    !rst_ni |=> (!irq_o || rst_ni));
endmodule

// File: tb/egpio_ctrl_tb_top.sv
module egpio_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_PINS   = 84;

  logic                clk = 1'b0;
  logic                rst_ni = 1'b0;
  logic                req_i = 1'b0, we_i = 1'b0;
  logic [7:0]          addr_i = '0;
  logic [31:0]         wdata_i = '0;
  logic [31:0]         rdata_o;
  logic [NUM_PINS-1:0] pin_i = '0;
  logic [NUM_PINS-1:0] pin_o, pin_oe_o;
  logic                irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } exp_t;
  exp_t sb_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  egpio_ctrl #(.NUM_PINS(NUM_PINS), .ADDR_W(8)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .pin_i(pin_i), .pin_o(pin_o), .pin_oe_o(pin_oe_o), .irq_o(irq_o)
  );

  // monitor: compares read data against the queued expectation
  always @(negedge clk) begin
    if (req_i && !we_i) begin
      checks++;
      if (sb_q.size() == 0) begin
        errors++;
        $display("FAIL read with no expectation: got %h", rdata_o);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        if (rdata_o !== e.exp) begin
          errors++;
          $display("FAIL %s: got %h expected %h", e.tag, rdata_o, e.exp);
        end
      end
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic idle(input int n);
    repeat (n) step();
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    step();
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    exp_t x;
    x.exp = e; x.tag = tag;
    sb_q.push_back(x);
    req_i = 1'b1; we_i = 1'b0; addr_i = a;
    step();
    req_i = 1'b0;
  endtask

  task automatic chk(input logic [31:0] got, input logic [31:0] e, input string tag);
    checks++;
    if (got !== e) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, e);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_ni = 1'b1;
    step();

    // R2 reset state
    chk({31'd0, irq_o}, 32'd0, "R2 irq after reset");
    chk(32'(pin_oe_o[31:0]), 32'd0, "R2 oe after reset");
    chk(32'(pin_o[31:0]), 32'd0, "R2 latch after reset");
    rd(8'h0C, 32'h0, "R2 dir b0 reset");
    rd(8'h34, 32'h0, "R2 rise b1 reset");
    rd(8'hA4, 32'h0, "R2 mask b2 reset");
    rd(8'h48, 32'h0, "R2 status b0 reset");

    // R5, R3, R4 output path
    wr(8'h0C, 32'h0000_00FF);
    chk(32'(pin_oe_o[31:0]), 32'h0000_00FF, "R5 oe follows dir");
    wr(8'h18, 32'h0000_00F0);
    chk(32'(pin_o[7:0]), 32'hF0, "R3 set word");
    wr(8'h24, 32'h0000_0030);
    chk(32'(pin_o[7:0]), 32'hC0, "R4 clear word");
    wr(8'h18, 32'h0);
    chk(32'(pin_o[7:0]), 32'hC0, "R3 zero bits keep latch");
    wr(8'h24, 32'h0);
    chk(32'(pin_o[7:0]), 32'hC0, "R4 zero bits keep latch");
    rd(8'h18, 32'h0, "R12 set reads zero");
    rd(8'h24, 32'h0, "R12 clear reads zero");

    // R6 level read with synchronizer
    pin_i[15:0] = 16'hA50F;
    step();
    rd(8'h00, 32'h0000_00C0, "R6 level one edge after change");
    rd(8'h00, 32'h0000_A5C0, "R6 level after sync");

    // R7 edge capture on bank 1
    wr(8'h34, 32'h5);   // rise: bit0, bit2
    wr(8'h40, 32'h6);   // fall: bit1, bit2
    pin_i[35:32] = 4'hF;
    idle(2);
    rd(8'h4C, 32'h0, "R7 not yet captured before third edge");
    rd(8'h4C, 32'h5, "R7 rising capture");
    pin_i[35:32] = 4'h0;
    idle(3);
    rd(8'h4C, 32'h7, "R7 falling capture, bit3 none");
    chk({31'd0, irq_o}, 32'd0, "R10 masked status keeps irq low");
    wr(8'hA0, 32'h2);
    chk({31'd0, irq_o}, 32'd1, "R10 unmasked status raises irq");

    // R8 sticky and write-one-to-clear
    wr(8'h4C, 32'h2);
    rd(8'h4C, 32'h5, "R8 clear one bit");
    chk({31'd0, irq_o}, 32'd0, "R10 irq drops after clear");
    wr(8'h4C, 32'h0);
    rd(8'h4C, 32'h5, "R8 zero write keeps status");
    wr(8'h4C, 32'hFFFF_FFFF);
    rd(8'h4C, 32'h0, "R8 all ones clears bank");

    // R9 edge and clear on the same edge
    pin_i[32] = 1'b1;
    idle(3);
    rd(8'h4C, 32'h1, "R9 setup captured");
    pin_i[32] = 1'b0;
    idle(3);
    pin_i[32] = 1'b1;
    idle(2);
    wr(8'h4C, 32'h1);
    rd(8'h4C, 32'h1, "R9 edge wins over clear");
    wr(8'h4C, 32'h1);
    rd(8'h4C, 32'h0, "R9 later clear works");

    // R11 partial last bank
    wr(8'h14, 32'hFFFF_FFFF);
    rd(8'h14, 32'h000F_FFFF, "R11 dir b2 trimmed");
    wr(8'hA4, 32'hFFFF_FFFF);
    rd(8'hA4, 32'h000F_FFFF, "R11 mask b2 trimmed");

    // R1 decode
    rd(8'h10, 32'h0, "R1 dir b1 word");
    wr(8'h0D, 32'hFFFF_FFFF);
    rd(8'h10, 32'h0, "R1 misaligned write ignored");
    wr(8'h60, 32'hFFFF_FFFF);
    rd(8'h60, 32'h0, "R1 unmapped reads zero");
    rd(8'hA8, 32'h0, "R1 past mask words");
    rd(8'h3C, 32'h0, "R1 fall b0 untouched");

    // R10 / R7 bank 2 pin mapping, top pin
    wr(8'h14, 32'h0);
    wr(8'h38, 32'h0008_0000);
    pin_i[83] = 1'b1;
    idle(3);
    rd(8'h50, 32'h0008_0000, "R7 bank2 top pin capture");
    chk({31'd0, irq_o}, 32'd1, "R10 bank2 irq");
    wr(8'h50, 32'hFFFF_FFFF);
    chk({31'd0, irq_o}, 32'd0, "R10 irq low after clear");

    idle(2);
    if (sb_q.size() != 0) begin
      errors++;
      $display("FAIL scoreboard: got %0d pending expected 0", sb_q.size());
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule